// File: doc/BRIEF.md
# Keyed Watchdog Timer

The block is a memory-mapped watchdog for a processor subsystem. A slow watchdog clock, delivered as a single-cycle enable `wd_tick` in the bus clock domain, passes through a fixed divide-by-32 prescaler into a timeout counter. The counter expires after a power-of-two number of prescaled ticks, chosen by a 5-bit postscaler field. Software keeps the system alive by writing a 16-bit key into the upper halfword of the control word. If the key does not arrive in time, the block pulses `rst_req` towards the system reset controller. It also latches a sticky cause flag that survives the resulting system reset.

Control bits can be changed atomically through clear and set alias addresses. A window mode punishes a key that arrives too early. The reset-cause flags record whether the processor was idle or asleep when the watchdog fired. They are cleared only by writing ones to them or by a power-on reset.

Top module: `keyed_wdog`

## Requirements
- R1: After either reset the control word reads 0 and `rst_req` is low. The status word is cleared by `por_n` only. A pulse on `rst_n` alone leaves it unchanged.
- R2: The control word is at byte address 0x00 with ON at bit 15, postscaler at bits 12:8, clock select at bits 7:6 and window enable at bit 0. All other bits read 0. Byte lane 0 writes bits 7:0 and lane 1 writes bits 15:8.
- R3: A write to 0x04 clears, and a write to 0x08 sets, exactly the control bits written as one in the enabled lanes. A read of either alias returns the control word.
- R4: With ON set and `wd_tick` high every cycle, `rst_req` rises 32·2^P cycles after the edge that enabled or restarted the counter, where P is the postscaler value. It stays high for one cycle, and the count then starts again.
- R5: A write of 0x5743 in bits 31:16 to address 0x00 with byte enables exactly 4'b1100 restarts the counter. Any other key value, or the key sent to an alias address, leaves the timeout time unchanged.
- R6: While ON is 0 the counter is held at zero, no `rst_req` is produced, and key writes have no effect. Setting ON restarts the count from zero.
- R7: In window mode, a valid key that arrives while the prescaled count is below 3/4 of the terminal count produces `rst_req` in the cycle after the write.
- R8: In window mode, a valid key at or beyond 3/4 of the terminal count restarts the counter without a reset request.
- R9: The status word is at 0x10. A reset request sets bit 4, sets bit 3 if `cpu_sleep` is high and sets bit 2 if `cpu_idle` is high. Writing ones to bits 4:2 at 0x14 clears them, and a set in the same cycle wins.
- R10: In the cycle right after ON changes from 1 to 0, writes are dropped and reads return 0.
- R11: Output `clk_sel` mirrors control bits 7:6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| por_n | input | 1 | Synchronous active-low power-on reset, also clears status |
| wd_tick | input | 1 | One-cycle enable per watchdog clock period |
| cpu_idle | input | 1 | Processor is in idle state |
| cpu_sleep | input | 1 | Processor is in sleep state |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 5 | Byte address |
| bus_be | input | 4 | Byte enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational in the access cycle |
| clk_sel | output | 2 | Watchdog clock source select |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
A write takes effect on the edge that ends its access cycle, and a read is sampled one time unit into the cycle. A timeout reaches `rst_req` exactly 32·2^P edges after the enabling or restarting edge. The bench therefore counts falling edges from the end of that write and compares the count with the computed value, so a request that comes one cycle early or late fails. A window violation is due on the edge that completes the key write, so it is checked as soon as that write returns. The blocked cycle after ON is cleared is probed at once, before any further edge.

// File: rtl/wdog_pkg.sv
// Shared constants for the keyed watchdog: address map, key value, field mask.
// Assumes a 5-bit byte address with 32-bit words.
package wdog_pkg;
    localparam int ADDR_W = 5;
    localparam logic [15:0] KEEP_KEY  = 16'h5743;
    localparam logic [15:0] CTRL_MASK = 16'h9FC1;
    localparam int ON_BIT = 15;
    localparam int WIN_BIT = 0;

    typedef enum logic [2:0] {
        W_CTRL    = 3'd0,
        W_CTRL_CL = 3'd1,
        W_CTRL_ST = 3'd2,
        W_STAT    = 3'd4,
        W_STAT_CL = 3'd5
    } word_e;
endpackage

// File: rtl/wdog_regs.sv
// Register file of the keyed watchdog: control word with set/clear aliases,
// key detection, sticky reset-cause flags and the blocked cycle after ON falls.
// Assumes single-cycle bus accesses and combinational read data.
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int PS_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              wd_event,
    input  logic              cpu_idle,
    input  logic              cpu_sleep,
    output logic              on_o,
    output logic              win_o,
    output logic [PS_W-1:0]   ps_o,
    output logic [1:0]        clk_sel_o,
    output logic              restart_o,
    output logic              key_o
);
    logic [15:0] ctrl_q, ctrl_d;
    logic [2:0]  st_q, st_d;
    logic        on_dly_q;
    logic        blk;
    logic        wr_ok;
    word_e       widx;

    assign widx  = word_e'(bus_addr[ADDR_W-1:2]);
    assign blk   = on_dly_q & ~ctrl_q[ON_BIT];
    assign wr_ok = bus_sel & bus_we & ~blk;

    // Next control word from plain, clear-alias and set-alias writes per lane.
    always_comb begin
        ctrl_d = ctrl_q;
        for (int b = 0; b < 2; b++) begin
            if (wr_ok && bus_be[b]) begin
                case (widx)
                    W_CTRL:    ctrl_d[8*b +: 8] = bus_wdata[8*b +: 8];
                    W_CTRL_CL: ctrl_d[8*b +: 8] = ctrl_q[8*b +: 8] & ~bus_wdata[8*b +: 8];
                    W_CTRL_ST: ctrl_d[8*b +: 8] = ctrl_q[8*b +: 8] | bus_wdata[8*b +: 8];
                    default:   ctrl_d[8*b +: 8] = ctrl_q[8*b +: 8];
                endcase
            end
        end
        ctrl_d = ctrl_d & CTRL_MASK;
    end

    // Next status flags: write-one-to-clear, then set on a watchdog event.
    always_comb begin
        st_d = st_q;
        if (wr_ok && widx == W_STAT_CL && bus_be[0]) st_d = st_q & ~bus_wdata[4:2];
        if (wd_event) st_d = st_d | {1'b1, cpu_sleep, cpu_idle};
    end

    // Control word and ON history, cleared by either reset.
    always_ff @(posedge clk) begin
        if (!rst_n || !por_n) begin
            ctrl_q   <= '0;
            on_dly_q <= 1'b0;
        end else begin
            ctrl_q   <= ctrl_d;
            on_dly_q <= ctrl_q[ON_BIT];
        end
    end

    // Sticky cause flags, cleared only by power-on reset.
    always_ff @(posedge clk) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Read mux; returns zero in the blocked cycle and for unmapped words.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_we && !blk) begin
            case (widx)
                W_CTRL, W_CTRL_CL, W_CTRL_ST: bus_rdata = {16'b0, ctrl_q};
                W_STAT, W_STAT_CL:            bus_rdata = {27'b0, st_q, 2'b0};
                default:                      bus_rdata = '0;
            endcase
        end
    end

    assign on_o      = ctrl_q[ON_BIT];
    assign win_o     = ctrl_q[WIN_BIT];
    assign ps_o      = ctrl_q[8 +: PS_W];
    assign clk_sel_o = ctrl_q[7:6];
    assign restart_o = ~ctrl_q[ON_BIT] & ctrl_d[ON_BIT];
    assign key_o     = wr_ok && widx == W_CTRL && bus_be == 4'b1100
                       && bus_wdata[31:16] == KEEP_KEY && ctrl_q[ON_BIT];

    AST_BLOCKED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        blk |=> ctrl_q == $past(ctrl_q)); // R10
    AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!por_n)
        wd_event |=> st_q[2]); // R9
    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (ctrl_q & ~CTRL_MASK) == 16'h0); // R2
endmodule

// File: rtl/wdog_timer.sv
// Prescaler and timeout counter of the keyed watchdog with window check.
// Assumes wd_tick is a synchronous one-cycle enable; produces a registered
// one-cycle reset request.
module wdog_timer #(
    parameter int PRESCALE = 32,
    parameter int PS_W     = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wd_tick,
    input  logic            on_i,
    input  logic            win_i,
    input  logic [PS_W-1:0] ps_i,
    input  logic            restart_i,
    input  logic            key_i,
    output logic            event_o,
    output logic            rst_req_o
);
    localparam int PRE_W = $clog2(PRESCALE);
    localparam int CNT_W = 1 << PS_W;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] term, thresh;
    logic             pt, tmo, viol;

    assign term    = CNT_W'(1) << ps_i;
    assign thresh  = (term >> 1) + (term >> 2);
    assign pt      = wd_tick && pre_q == PRE_LAST;
    assign tmo     = on_i && pt && cnt_q >= term - CNT_W'(1);
    assign viol    = key_i && win_i && cnt_q < thresh;
    assign event_o = tmo || viol;

    // Prescaler, counter and reset request pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q     <= '0;
            cnt_q     <= '0;
            rst_req_o <= 1'b0;
        end else begin
            rst_req_o <= event_o;
            if (!on_i || restart_i || key_i || event_o) begin
                pre_q <= '0;
                cnt_q <= '0;
            end else if (wd_tick) begin
                pre_q <= pre_q + PRE_W'(1);
                if (pt) cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !on_i |=> !rst_req_o); // R6
    AST_OFF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !on_i |=> cnt_q == '0 && pre_q == '0); // R6
    AST_KEY_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        key_i |=> cnt_q == '0 && pre_q == '0); // R5
    AST_VIOL_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        viol |=> rst_req_o); // R7
endmodule

// File: rtl/keyed_wdog.sv
// Top of the keyed watchdog: joins the register file and the timer.
// Assumes rst_n is the system reset driven by rst_req and por_n the power-on reset.
module keyed_wdog
    import wdog_pkg::*;
#(
    parameter int PRESCALE = 32,
    parameter int PS_W     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              wd_tick,
    input  logic              cpu_idle,
    input  logic              cpu_sleep,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [1:0]        clk_sel,
    output logic              rst_req
);
    logic            sys_rst_n;
    logic            on, win, restart, key, wd_event;
    logic [PS_W-1:0] ps;

    assign sys_rst_n = rst_n & por_n;

    wdog_regs #(.PS_W(PS_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .por_n(por_n),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wd_event(wd_event), .cpu_idle(cpu_idle), .cpu_sleep(cpu_sleep),
        .on_o(on), .win_o(win), .ps_o(ps), .clk_sel_o(clk_sel),
        .restart_o(restart), .key_o(key)
    );

    wdog_timer #(.PRESCALE(PRESCALE), .PS_W(PS_W)) u_timer (
        .clk(clk), .rst_n(sys_rst_n), .wd_tick(wd_tick),
        .on_i(on), .win_i(win), .ps_i(ps), .restart_i(restart), .key_i(key),
        .event_o(wd_event), .rst_req_o(rst_req)
    );
endmodule

// File: tb/keyed_wdog_tb.sv
module keyed_wdog_tb_top;
    logic        clk = 1'b0;
    logic        rst_n, por_n, wd_tick, cpu_idle, cpu_sleep;
    logic        bus_sel, bus_we;
    logic [4:0]  bus_addr;
    logic [3:0]  bus_be;
    logic [31:0] bus_wdata, bus_rdata;
    logic [1:0]  clk_sel;
    logic        rst_req;
    int          errors = 0;
    int          checks = 0;
    int          cyc = 0;
    logic [31:0] rd;
    int          k;

    always #2.5 clk = ~clk;

    keyed_wdog dut_i (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .wd_tick(wd_tick),
        .cpu_idle(cpu_idle), .cpu_sleep(cpu_sleep), .bus_sel(bus_sel),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .clk_sel(clk_sel),
        .rst_req(rst_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [4:0] a, input logic [3:0] be, input logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a; bus_be = 4'hF;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    // Counts falling edges until rst_req is seen; returns limit+1 if never.
    task automatic wait_req(input int limit, output int n);
        n = limit + 1;
        for (int i = 1; i <= limit; i++) begin
            @(negedge clk);
            if (rst_req) begin n = i; break; end
        end
    endtask

    task automatic turn_off();
        bus_wr(5'h04, 4'b0010, 32'h8000);
        @(negedge clk);
    endtask

    task automatic t_reset();
        bus_rd(5'h00, rd); chk("R1 ctrl after reset", rd, 32'h0);
        bus_rd(5'h10, rd); chk("R1 status after reset", rd, 32'h0);
        chk("R1 rst_req after reset", {31'b0, rst_req}, 32'h0);
    endtask

    task automatic t_fields();
        bus_wr(5'h00, 4'b0001, 32'hFFFF_FFFF);
        bus_rd(5'h00, rd); chk("R2 lane0 write", rd, 32'h00C1);
        chk("R11 clk_sel", {30'b0, clk_sel}, 32'h3);
        bus_wr(5'h00, 4'b0011, 32'hFFFF_FFFF);
        bus_rd(5'h00, rd); chk("R2 full fields", rd, 32'h9FC1);
        bus_rd(5'h08, rd); chk("R3 read via set alias", rd, 32'h9FC1);
        bus_wr(5'h04, 4'b0001, 32'h0000_00C0);
        bus_rd(5'h04, rd); chk("R3 clear alias clk_sel", rd, 32'h9F01);
        chk("R11 clk_sel cleared", {30'b0, clk_sel}, 32'h0);
    endtask

    task automatic t_blocked();
        // ctrl is 0x9F01 here
        bus_wr(5'h04, 4'b0010, 32'h8000);
        bus_wr(5'h08, 4'b0001, 32'h0040);       // dropped in blocked cycle
        bus_rd(5'h00, rd); chk("R10 write dropped", rd, 32'h1F01);
        bus_wr(5'h08, 4'b0010, 32'h8000);
        bus_wr(5'h04, 4'b0010, 32'h8000);
        bus_rd(5'h00, rd); chk("R10 read returns zero", rd, 32'h0);
        bus_rd(5'h00, rd); chk("R10 read after blocked cycle", rd, 32'h1F01);
        bus_wr(5'h04, 4'b0011, 32'hFFFF);
        @(negedge clk);
    endtask

    task automatic t_timeout();
        bus_wr(5'h00, 4'b0011, 32'h0);
        bus_wr(5'h08, 4'b0010, 32'h8000);
        wait_req(200, k); chk("R4 timeout P=0 cycles", k, 32);
        @(negedge clk); chk("R4 pulse one cycle", {31'b0, rst_req}, 0);
        wait_req(200, k); chk("R4 recount after timeout", k, 31);
        bus_rd(5'h10, rd); chk("R9 cause bit4", rd, 32'h10);
        turn_off();
        bus_wr(5'h00, 4'b0011, 32'h8100);
        wait_req(200, k); chk("R4 timeout P=1 cycles", k, 64);
        turn_off();
    endtask

    task automatic t_key();
        bus_wr(5'h00, 4'b0011, 32'h8100);
        repeat (40) @(negedge clk);
        bus_wr(5'h00, 4'b1100, 32'h5743_0000);
        wait_req(200, k); chk("R5 key restarts", k, 64);
        turn_off();
        bus_wr(5'h00, 4'b0011, 32'h8100);
        repeat (20) @(negedge clk);
        bus_wr(5'h00, 4'b1100, 32'h1234_0000);
        bus_wr(5'h08, 4'b1100, 32'h5743_0000);
        wait_req(200, k); chk("R5 bad key or alias ignored", k, 42);
        turn_off();
    endtask

    task automatic t_off();
        int seen = 0;
        bus_wr(5'h00, 4'b0011, 32'h0000);
        bus_wr(5'h00, 4'b1100, 32'h5743_0000);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (rst_req) seen++;
        end
        chk("R6 no request while off", seen, 0);
        bus_wr(5'h08, 4'b0010, 32'h8000);
        wait_req(200, k); chk("R6 setting ON starts from zero", k, 32);
        turn_off();
    endtask

    task automatic t_window();
        int seen = 0;
        bus_wr(5'h00, 4'b0011, 32'h8201);
        repeat (10) @(negedge clk);
        bus_wr(5'h00, 4'b1100, 32'h5743_0000);
        chk("R7 early key violation", {31'b0, rst_req}, 1);
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (rst_req) seen++;
        end
        chk("R8 no request before late key", seen, 0);
        bus_wr(5'h00, 4'b1100, 32'h5743_0000);
        chk("R8 late key accepted", {31'b0, rst_req}, 0);
        wait_req(300, k); chk("R8 restart after late key", k, 128);
        turn_off();
    endtask

    task automatic t_status();
        bus_wr(5'h14, 4'b0001, 32'h1C);
        bus_rd(5'h10, rd); chk("R9 W1C all", rd, 32'h0);
        cpu_idle = 1'b1;
        bus_wr(5'h00, 4'b0011, 32'h8000);
        wait_req(200, k);
        turn_off();
        cpu_idle = 1'b0;
        bus_rd(5'h10, rd); chk("R9 idle cause", rd, 32'h14);
        bus_wr(5'h14, 4'b0001, 32'h10);
        bus_rd(5'h10, rd); chk("R9 W1C bit4 only", rd, 32'h04);
        cpu_sleep = 1'b1;
        bus_wr(5'h00, 4'b0011, 32'h8000);
        wait_req(200, k);
        turn_off();
        cpu_sleep = 1'b0;
        bus_rd(5'h10, rd); chk("R9 sleep cause", rd, 32'h1C);
        bus_wr(5'h00, 4'b0011, 32'h0081);
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
        bus_rd(5'h10, rd); chk("R1 status survives rst_n", rd, 32'h1C);
        bus_rd(5'h00, rd); chk("R1 ctrl cleared by rst_n", rd, 32'h0);
        por_n = 1'b0; @(negedge clk); por_n = 1'b1; @(negedge clk);
        bus_rd(5'h10, rd); chk("R1 status cleared by por_n", rd, 32'h0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=%0d expected<=100000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; por_n = 1'b0; wd_tick = 1'b1; cpu_idle = 1'b0; cpu_sleep = 1'b0;
        bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_be = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; por_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fields();
        t_blocked();
        t_timeout();
        t_key();
        t_off();
        t_window();
        t_status();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule